// File: doc/BRIEF.md
# Nine-Bit Word Byte Packer

This block sits in front of a serial engine that can only shift whole 8-bit bytes, while the display controller on the far side expects 9-bit words: one command/data flag followed by one byte. Bytes arrive on a ready/valid stream, each with its flag and an end-of-group marker. The block gathers eight such words and emits them as exactly nine bytes, with the bits packed back to back. The serial engine then shifts those nine bytes out, and the far side sees eight clean 9-bit words.

A group shorter than eight words is filled with no-op words, which are all zeros with the flag clear. Where the filler goes depends on the group. A command group is pushed to the end of the block, so that seven no-ops come first and the controller sees the command last. A data group stays at the front and the no-ops trail it. A `swap_pairs` input handles 16-bit pixel data held little-endian in memory: with it set, each pair of data bytes is exchanged before packing, so the high byte travels first.

Top module: `nine_bit_packer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a partly gathered group, `in_ready` is 1, `out_valid` is 0, and the next block contains no leftover words.
- R2: For a block of eight words, word k (k = 0..7, in arrival order) places its flag bit at bit 7-k of output byte k. Its 8 value bits follow, MSB first, in the bit positions directly below that flag, continuing into byte k+1. The 72 bits fill the nine bytes with no gaps.
- R3: Every block leaves as exactly nine bytes, first byte first. While `out_valid`=1 and `out_ready`=0, `out_byte` holds its value. `out_valid` drops after the ninth accepted byte.
- R4: A group whose final word has flag 0 (a command) is right-aligned in its block, with zero words filling the earlier slots. A lone command byte C therefore gives eight 0x00 bytes followed by C.
- R5: A group whose final word has flag 1 (data) with fewer than eight words keeps its words in slots 0..n-1, and zero words fill slots n..7.
- R6: With `swap_pairs`=1, data words are exchanged in pairs (words 2i and 2i+1 change places). A final unpaired data word stays in its own slot.
- R7: `in_ready` is 0 from the cycle after a block closes until its ninth byte has been accepted. No input byte is taken in that window.
- R8: A word with `in_last`=1 closes the block at once. The eighth word closes it with or without `in_last`, and `in_last` on the eighth word adds no extra block.
- R9: `swap_pairs` has no effect on words whose flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| swap_pairs | input | 1 | Exchange data bytes in pairs; hold steady for a whole group |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Input byte value |
| in_dc | input | 1 | Flag of the word: 0 command, 1 data |
| in_last | input | 1 | Final word of the group |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Serial engine takes the output byte |
| out_byte | output | 8 | Packed output byte |

## Verification
Two conditions are hard to reach from the ports. The first is a reset arriving while a group is only partly gathered: words have already been written into slots and nothing has closed the block. The bench feeds three data bytes without an end marker, pulls reset, and then sends a lone command whose expected image is eight zero bytes and the command. Any surviving slot would show up as a non-zero byte. The second is stray input offered during a drain. The bench holds `in_valid` high with a junk byte while the first bytes of every block are being stalled by a toggling `out_ready`, and then checks that the next block contains only its own words.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic             dc;
    logic [BYTE_W-1:0] val;
  } nbp_word_t;

  localparam int WORD_W = $bits(nbp_word_t);
endpackage

// File: rtl/nbp_rst_sync.sv
module nbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/nbp_gather.sv
module nbp_gather
  import nbp_pkg::*;
#(
  parameter int NWORD = 8,
  localparam int CW = $clog2(NWORD + 1),
  localparam int IW = $clog2(NWORD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    swap_pairs,
  input  logic                    in_valid,
  input  logic [BYTE_W-1:0]       in_byte,
  input  logic                    in_dc,
  input  logic                    in_last,
  input  logic                    drain_busy,
  input  logic                    take,
  output logic                    in_ready,
  output logic                    blk_full,
  output logic                    rtail,
  output logic [CW-1:0]           fill,
  output nbp_word_t [NWORD-1:0]   words
);
  nbp_word_t [NWORD-1:0] word_q, word_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  full_q, full_d;
  logic                  rtail_q, rtail_d;
  logic                  fire, close, pair_sw, en;
  logic [IW-1:0]         base, slot;

  assign in_ready = !full_q && !drain_busy;
  assign fire     = in_valid && in_ready;
  assign close    = fire && (in_last || (cnt_q == CW'(NWORD - 1)));
  assign base     = cnt_q[IW-1:0];
  assign pair_sw  = swap_pairs && in_dc;
  assign en       = fire || take;

  // pair exchange: the even word goes one slot up unless it ends the group
  always_comb begin
    if (pair_sw && !base[0] && !in_last) slot = base + IW'(1);
    else if (pair_sw && base[0])         slot = base - IW'(1);
    else                                 slot = base;
  end

  always_comb begin
    word_d  = word_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    rtail_d = rtail_q;
    if (take) begin
      word_d = '0;
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (fire) begin
      word_d[slot].dc  = in_dc;
      word_d[slot].val = in_byte;
      cnt_d            = cnt_q + CW'(1);
      if (close) begin
        full_d  = 1'b1;
        rtail_d = !in_dc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rtail_q <= 1'b0;
    end else if (en) begin
      word_q  <= word_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      rtail_q <= rtail_d;
    end
  end

  assign blk_full = full_q;
  assign rtail    = rtail_q;
  assign fill     = cnt_q;
  assign words    = word_q;
endmodule

// File: rtl/nbp_align.sv
module nbp_align
  import nbp_pkg::*;
#(
  parameter int NWORD = 8,
  localparam int CW    = $clog2(NWORD + 1),
  localparam int IW    = $clog2(NWORD),
  localparam int BLK_W = NWORD * WORD_W
) (
  input  nbp_word_t [NWORD-1:0] words,
  input  logic [CW-1:0]         fill,
  input  logic                  rtail,
  output logic [BLK_W-1:0]      image
);
  logic [CW-1:0]         shift;
  nbp_word_t [NWORD-1:0] placed;

  assign shift = rtail ? (CW'(NWORD) - fill) : '0;

  always_comb begin
    for (int k = 0; k < NWORD; k++) begin
      logic [CW-1:0] idx;
      idx = CW'(k) - shift;
      if (CW'(k) >= shift) placed[k] = words[idx[IW-1:0]];
      else                 placed[k] = '0;
    end
  end

  // word k sits at the k-th 9-bit field counted from the top of the image
  for (genvar k = 0; k < NWORD; k++) begin : g_field
    assign image[BLK_W-1-k*WORD_W -: WORD_W] = placed[k];
  end
endmodule

// File: rtl/nbp_drain.sv
module nbp_drain
  import nbp_pkg::*;
#(
  parameter int NWORD = 8,
  localparam int BLK_W = NWORD * WORD_W,
  localparam int NBYTE = BLK_W / BYTE_W,
  localparam int LW    = $clog2(NBYTE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BLK_W-1:0]  image,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              busy
);
  logic [BLK_W-1:0] sr_q, sr_d;
  logic [LW-1:0]    left_q, left_d;
  logic             busy_q, busy_d;
  logic             hs, en;

  assign hs = busy_q && out_ready;
  assign en = take || hs;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    busy_d = busy_q;
    if (take) begin
      sr_d   = image;
      left_d = LW'(NBYTE);
      busy_d = 1'b1;
    end else if (hs) begin
      sr_d   = {sr_q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      left_d = left_q - LW'(1);
      busy_d = (left_q != LW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      sr_q   <= sr_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign out_valid = busy_q;
  assign out_byte  = sr_q[BLK_W-1 -: BYTE_W];
  assign busy      = busy_q;
endmodule

// File: rtl/nine_bit_packer.sv
module nine_bit_packer
  import nbp_pkg::*;
#(
  parameter int NWORD = 8,
  localparam int CW    = $clog2(NWORD + 1),
  localparam int BLK_W = NWORD * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_pairs,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_dc,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  logic                  rst_i_n, busy, blk_full, rtail, take;
  logic [CW-1:0]         fill;
  nbp_word_t [NWORD-1:0] words;
  logic [BLK_W-1:0]      image;

  assign take = blk_full && !busy;

  nbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  nbp_gather #(.NWORD(NWORD)) u_gather (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .swap_pairs (swap_pairs),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_dc      (in_dc),
    .in_last    (in_last),
    .drain_busy (busy),
    .take       (take),
    .in_ready   (in_ready),
    .blk_full   (blk_full),
    .rtail      (rtail),
    .fill       (fill),
    .words      (words)
  );

  nbp_align #(.NWORD(NWORD)) u_align (
    .words (words),
    .fill  (fill),
    .rtail (rtail),
    .image (image)
  );

  nbp_drain #(.NWORD(NWORD)) u_drain (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .take      (take),
    .image     (image),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .busy      (busy)
  );
endmodule

// File: rtl/nbp_checker.sv
module nbp_checker #(
  parameter int NBYTE = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  localparam int OW = $clog2(NBYTE);
  logic [OW-1:0] ocnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocnt_q <= '0;
    else if (out_valid && out_ready)
      ocnt_q <= (ocnt_q == OW'(NBYTE - 1)) ? '0 : ocnt_q + OW'(1);
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  p_nine_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ocnt_q == '0);

  p_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && ocnt_q == OW'(NBYTE - 1) |=> !out_valid);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);
endmodule

bind nine_bit_packer nbp_checker #(.NBYTE(9)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte)
);

// File: tb/sim_nine_bit_packer.sv
module sim_nine_bit_packer;
  logic       clk, rst_n, swap_pairs, in_valid, in_ready, in_dc, in_last;
  logic       out_valid, out_ready;
  logic [7:0] in_byte, out_byte;
  int         nchk = 0, nfail = 0;

  typedef struct packed {
    logic [3:0]  n;
    logic        dc;
    logic        sw;
    logic        lst;
    logic [63:0] b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd8, 1'b1, 1'b0, 1'b1, 64'h0123456789ABCDEF},  // R2 full data block
    '{4'd1, 1'b0, 1'b0, 1'b1, 64'h2C00000000000000},  // R4 lone command
    '{4'd3, 1'b1, 1'b0, 1'b1, 64'hA55AFF0000000000},  // R5 short data
    '{4'd8, 1'b1, 1'b1, 1'b1, 64'h1122334455667788},  // R6 swapped pairs
    '{4'd5, 1'b1, 1'b1, 1'b1, 64'hC3D4E5F607000000},  // R6 odd tail
    '{4'd1, 1'b0, 1'b1, 1'b1, 64'h3A00000000000000},  // R9 command ignores swap
    '{4'd8, 1'b1, 1'b0, 1'b0, 64'hFEDCBA9876543210},  // R8 closed by count
    '{4'd4, 1'b1, 1'b0, 1'b1, 64'h8001807F00000000}   // R5 short data
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R6";
      5: return "R9";
      6: return "R8";
      default: return "R5";
    endcase
  endfunction

  // reference image from the requirements: slot placement, then bit layout
  function automatic logic [71:0] model(vec_t v);
    logic [8:0]  w [8];
    logic [71:0] img;
    int          s;
    for (int i = 0; i < 8; i++) w[i] = '0;
    for (int i = 0; i < int'(v.n); i++) begin
      s = i;
      if (!v.dc) s = 8 - int'(v.n) + i;
      else if (v.sw) begin
        if ((i % 2) == 0 && i + 1 < int'(v.n)) s = i + 1;
        else if ((i % 2) == 1) s = i - 1;
      end
      w[s] = {v.dc, v.b[63-8*i -: 8]};
    end
    for (int b = 0; b < 72; b++) img[71-b] = w[b/9][8-(b%9)];
    return img;
  endfunction

  nine_bit_packer u0 (
    .clk(clk), .rst_n(rst_n), .swap_pairs(swap_pairs), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_dc(in_dc), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(vec_t v);
    for (int i = 0; i < int'(v.n); i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_byte    = v.b[63-8*i -: 8];
      in_dc      = v.dc;
      swap_pairs = v.sw;
      in_last    = v.lst && (i == int'(v.n) - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  // collects nine bytes under a stalling out_ready, offering junk input meanwhile
  task automatic collect(string tag, logic [71:0] exp);
    int j = 0, t = 0;
    in_valid = 1'b1;
    in_byte  = 8'hEE;
    in_dc    = 1'b1;
    while (j < 9) begin
      @(negedge clk);
      if (j >= 4) in_valid = 1'b0;
      out_ready = (t % 3) != 1;
      t++;
      if (out_valid && out_ready) begin
        check(tag, $sformatf("byte %0d", j), out_byte, exp[71-8*j -: 8]);
        if (in_ready) check("R7", "in_ready while draining", 8'(in_ready), 8'h0);
        j++;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    check("R3", "out_valid after nine bytes", 8'(out_valid), 8'h0);
    check("R7", "in_ready after drain", 8'(in_ready), 8'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; swap_pairs = 1'b0; in_valid = 1'b0; in_byte = '0;
    in_dc = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "in_ready after reset", 8'(in_ready), 8'h1);
    check("R1", "out_valid after reset", 8'(out_valid), 8'h0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      collect(vtag(i), model(VECS[i]));
    end

    // R4 hand-worked: command 0x2C gives eight zero bytes then 0x2C
    send('{4'd1, 1'b0, 1'b0, 1'b1, 64'h2C00000000000000});
    collect("R4", 72'h00_0000_0000_0000_002C);

    // R5 hand-worked: single data byte 0xFF gives FF 80 then zeros
    send('{4'd1, 1'b1, 1'b0, 1'b1, 64'hFF00000000000000});
    collect("R5", 72'hFF_8000_0000_0000_0000);

    // R1: reset in the middle of a partial group leaves nothing behind
    send('{4'd3, 1'b1, 1'b0, 1'b0, 64'hFFFFFF0000000000});
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "in_ready after mid reset", 8'(in_ready), 8'h1);
    check("R1", "out_valid after mid reset", 8'(out_valid), 8'h0);
    send('{4'd1, 1'b0, 1'b0, 1'b1, 64'h5100000000000000});
    collect("R1", 72'h00_0000_0000_0000_0051);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule